// File: doc/BRIEF.md
# Remote Segment Translator and Link Steerer

This block sits behind one bus master port of a compute node whose memory map includes segments of remote memory. Each request flit enters with a compute-side address. On the first flit of a transaction the block compares the address with a small table of allocated segment ranges. The matching entry supplies two things: an offset that moves the address into the owning memory node's local space, and the number of the serial link that reaches that node. The flit is tagged with this master's identifier and sent through a 1-to-N crossbar to the transmit queue of that link. No destination node field is added, because the chosen link already leads to the right node.

Software loads or clears table entries at run time through a one-cycle write port. Later flits of the same transaction reuse the decision made on the first flit. A request whose start address hits no valid entry is consumed without being forwarded. It raises an error strobe and advances a saturating miss counter. A full transmit queue stalls the master port.

Top module: `seg_steer`

## Requirements
- R1: After reset every table entry is invalid and `miss_cnt` is 0, so any start flit is treated as a miss.
- R2: A start flit hits entry i when that entry is valid and lo_i <= address <= hi_i (both bounds inclusive). It is then presented on `out_valid[link_i]` only, with `out_addr` = (address + off_i) mod 2^AW, so a negative offset is written in two's complement.
- R3: When several valid entries contain the address, the entry with the lowest index decides the offset and the link.
- R4: A start flit that hits no valid entry drives no `out_valid` bit, is consumed (`in_ready` = 1), and pulses `err_miss` in the same cycle. It adds 1 to `miss_cnt` at the next edge, and the counter holds at its all-ones value once it reaches it.
- R5: Every forwarded flit carries `out_mid` = MASTER_ID, with `out_data`, `out_sof` and `out_eof` unchanged.
- R6: A flit with `in_sof` = 0 reuses the hit/miss result, offset and link latched from the last accepted start flit. A table write made after that start flit does not change them.
- R7: `in_ready` equals `out_ready` of the selected link for a hitting flit. `out_valid` does not depend on `out_ready`, and the `out_ready` bits of other links are ignored.
- R8: `cfg_we` with `cfg_set` = 1 loads entry `cfg_idx` (lo, hi, off, link) and marks it valid, and with `cfg_set` = 0 marks it invalid. The change is seen by lookups from the next cycle on. A lookup in the same cycle as the write uses the old entry.
- R9: Continuation flits of a missed transaction are consumed silently: no `out_valid`, no `err_miss`, no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_set | input | 1 | 1 = load entry and mark valid, 0 = clear entry |
| cfg_idx | input | clog2(N_SEG) | Entry index |
| cfg_lo | input | AW | Lowest compute-side address of the segment |
| cfg_hi | input | AW | Highest compute-side address of the segment |
| cfg_off | input | AW | Offset added to form the remote address |
| cfg_link | input | clog2(N_LINK) | Transmit link for the segment |
| in_valid | input | 1 | Request flit valid |
| in_ready | output | 1 | Request flit accepted |
| in_sof | input | 1 | First flit of a transaction |
| in_eof | input | 1 | Last flit of a transaction |
| in_addr | input | AW | Compute-side address |
| in_data | input | DW | Flit payload |
| out_valid | output | N_LINK | Per-link flit valid |
| out_ready | input | N_LINK | Per-link queue has room |
| out_sof | output | 1 | Forwarded start marker |
| out_eof | output | 1 | Forwarded end marker |
| out_addr | output | AW | Translated address |
| out_data | output | DW | Forwarded payload |
| out_mid | output | MID_W | Originating master tag |
| err_miss | output | 1 | Start flit matched no valid entry |
| miss_cnt | output | CNT_W | Saturating miss count |

## Verification
Two functions can land in the same cycle: a table write and a lookup that depends on the entry being written. Either the write clears an entry while a start flit targets it, or it rewrites an entry while a transaction routed through it is still sending flits. The bench issues the write on the same clock edge as the flit. It then expects the old entry to decide that flit and the new entry to decide the next start flit. It also expects the continuation flits of the open transaction to keep their original link and offset.

// File: rtl/seg_steer.sv
module seg_steer #(
  parameter int AW        = 40,
  parameter int DW        = 64,
  parameter int N_LINK    = 4,
  parameter int N_SEG     = 8,
  parameter int MID_W     = 2,
  parameter int MASTER_ID = 0,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_set,
  input  logic [$clog2(N_SEG)-1:0]  cfg_idx,
  input  logic [AW-1:0]     cfg_lo,
  input  logic [AW-1:0]     cfg_hi,
  input  logic [AW-1:0]     cfg_off,
  input  logic [$clog2(N_LINK)-1:0] cfg_link,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [AW-1:0]     in_addr,
  input  logic [DW-1:0]     in_data,
  output logic [N_LINK-1:0] out_valid,
  input  logic [N_LINK-1:0] out_ready,
  output logic              out_sof,
  output logic              out_eof,
  output logic [AW-1:0]     out_addr,
  output logic [DW-1:0]     out_data,
  output logic [MID_W-1:0]  out_mid,
  output logic              err_miss,
  output logic [CNT_W-1:0]  miss_cnt
);
  localparam int IW = $clog2(N_SEG);
  localparam int LW = $clog2(N_LINK);

  logic [N_SEG-1:0] t_val;
  logic [AW-1:0]    t_lo   [N_SEG];
  logic [AW-1:0]    t_hi   [N_SEG];
  logic [AW-1:0]    t_off  [N_SEG];
  logic [LW-1:0]    t_link [N_SEG];

  always_ff @(posedge clk) begin
    if (!rst_n) t_val <= '0;
    else if (cfg_we) t_val[cfg_idx] <= cfg_set;
  end

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_set) begin
      t_lo[cfg_idx]   <= cfg_lo;
      t_hi[cfg_idx]   <= cfg_hi;
      t_off[cfg_idx]  <= cfg_off;
      t_link[cfg_idx] <= cfg_link;
    end
  end

  logic [N_SEG-1:0] match;
  for (genvar i = 0; i < N_SEG; i++) begin : g_cmp
    assign match[i] = t_val[i] && (in_addr >= t_lo[i]) && (in_addr <= t_hi[i]);
  end

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = N_SEG - 1; i >= 0; i--)
      if (match[i]) sel = IW'(i);
  end

  wire           lk_hit  = |match;
  wire [AW-1:0]  lk_off  = t_off[sel];
  wire [LW-1:0]  lk_link = t_link[sel];

  logic          h_hit;
  logic [AW-1:0] h_off;
  logic [LW-1:0] h_link;

  wire           r_hit  = in_sof ? lk_hit  : h_hit;
  wire [AW-1:0]  r_off  = in_sof ? lk_off  : h_off;
  wire [LW-1:0]  r_link = in_sof ? lk_link : h_link;

  assign in_ready = r_hit ? out_ready[r_link] : 1'b1;

  for (genvar k = 0; k < N_LINK; k++) begin : g_xbar
    assign out_valid[k] = in_valid && r_hit && (r_link == LW'(k));
  end

  assign out_addr = in_addr + r_off;
  assign out_data = in_data;
  assign out_sof  = in_sof;
  assign out_eof  = in_eof;
  assign out_mid  = MID_W'(MASTER_ID);
  assign err_miss = in_valid && in_sof && !lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_hit  <= 1'b0;
      h_off  <= '0;
      h_link <= '0;
    end else if (in_valid && in_ready && in_sof) begin
      h_hit  <= lk_hit;
      h_off  <= lk_off;
      h_link <= lk_link;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) miss_cnt <= '0;
    else if (err_miss && miss_cnt != '1) miss_cnt <= miss_cnt + CNT_W'(1);
  end

  p_one_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |-> !in_ready);

  p_no_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_miss |-> (out_valid == '0) && in_ready);

  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_miss && miss_cnt != '1) |=> miss_cnt == $past(miss_cnt) + CNT_W'(1));

  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !err_miss |=> $stable(miss_cnt));

  p_cont_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof) |-> !err_miss);
endmodule

// File: tb/seg_steer_test.sv
`timescale 1ns/100ps
module seg_steer_test;
  localparam int AW = 40, DW = 16, NL = 4, NS = 8, MW = 2, MID = 2, CW = 4;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic cfg_we = 0, cfg_set = 0;
  logic [2:0] cfg_idx = 0;
  logic [AW-1:0] cfg_lo = 0, cfg_hi = 0, cfg_off = 0;
  logic [1:0] cfg_link = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [AW-1:0] in_addr = 0;
  logic [DW-1:0] in_data = 0;
  logic [NL-1:0] out_ready = '1;
  logic in_ready, out_sof, out_eof, err_miss;
  logic [NL-1:0] out_valid;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic [MW-1:0] out_mid;
  logic [CW-1:0] miss_cnt;

  seg_steer #(.AW(AW), .DW(DW), .N_LINK(NL), .N_SEG(NS), .MID_W(MW),
              .MASTER_ID(MID), .CNT_W(CW)) uut (.*);

  int checks = 0, fails = 0;
  logic [AW-1:0] m_lo [NS], m_hi [NS], m_off [NS];
  logic [1:0] m_link [NS];
  logic [NS-1:0] m_val = '0;
  bit b_hit = 0; logic [AW-1:0] b_off = 0; logic [1:0] b_link = 0;
  int exp_miss = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int look(logic [AW-1:0] a);
    for (int i = 0; i < NS; i++)
      if (m_val[i] && a >= m_lo[i] && a <= m_hi[i]) return i;
    return -1;
  endfunction

  task automatic cfg(int idx, bit set, logic [AW-1:0] lo, hi, off, logic [1:0] lk);
    @(negedge clk);
    cfg_we = 1; cfg_set = set; cfg_idx = 3'(idx);
    cfg_lo = lo; cfg_hi = hi; cfg_off = off; cfg_link = lk;
    @(posedge clk); #1 cfg_we = 0;
    m_val[idx] = set;
    if (set) begin m_lo[idx] = lo; m_hi[idx] = hi; m_off[idx] = off; m_link[idx] = lk; end
  endtask

  // drives one flit on a negedge and checks outputs against the bench model
  task automatic flit(bit sof, bit eof, logic [AW-1:0] a, logic [NL-1:0] rdy, string req);
    int e; bit hit; logic [AW-1:0] off; logic [1:0] lk; logic [NL-1:0] ev; bit er, ir;
    @(negedge clk);
    chk(miss_cnt == CW'(exp_miss > 15 ? 15 : exp_miss), "R4 count", 64'(miss_cnt), 64'(exp_miss));
    in_valid = 1; in_sof = sof; in_eof = eof; in_addr = a; in_data = DW'(a ^ 40'h5a5a); out_ready = rdy;
    e = look(a);
    if (sof) begin hit = (e >= 0); off = hit ? m_off[e] : '0; lk = hit ? m_link[e] : '0; end
    else begin hit = b_hit; off = b_off; lk = b_link; end
    ev = hit ? NL'(1) << lk : '0;
    er = sof && !hit;
    ir = hit ? rdy[lk] : 1'b1;
    #1;
    chk(out_valid == ev, req, 64'(out_valid), 64'(ev));
    chk(err_miss == er, req, 64'(err_miss), 64'(er));
    chk(in_ready == ir, req, 64'(in_ready), 64'(ir));
    if (hit) begin
      chk(out_addr == a + off, req, 64'(out_addr), 64'(a + off));
      chk(out_mid == MW'(MID) && out_data == DW'(a ^ 40'h5a5a) && out_sof == sof && out_eof == eof,
          "R5 tag", 64'(out_mid), 64'(MID));
    end
    if (er) exp_miss++;
    if (sof && ir) begin b_hit = hit; b_off = off; b_link = lk; end
    @(posedge clk); #1 in_valid = 0; out_ready = '1;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] lo;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(miss_cnt == 0 && err_miss == 0 && out_valid == 0, "R1 reset", 64'(miss_cnt), 0);
    flit(1, 1, 40'h0, '1, "R1 empty table");
    flit(1, 1, 40'h8_0000_0000, '1, "R1 empty table");

    // entry 0: 512 MiB segment moved down into the remote node's space
    cfg(0, 1, 40'h8_0000_0000, 40'h8_1FFF_FFFF, 40'h20000000 - 40'h8_0000_0000, 2'd1);
    for (int i = 1; i < NS; i++)
      cfg(i, 1, 40'h10_0000_0000 + 40'(i) * 40'h1000, 40'h10_0000_07FF + 40'(i) * 40'h1000,
          40'(i) * 40'h111, 2'(i % NL));
    flit(1, 1, 40'h8_0000_0000, '1, "R2 example low");
    chk(out_addr == 40'h2000_0000, "R2 example", 64'(out_addr), 64'h2000_0000);
    flit(1, 1, 40'h8_1FFF_FFFF, '1, "R2 example high");
    for (int i = 0; i < NS; i++) begin
      lo = m_lo[i];
      flit(1, 1, lo - 1, '1, "R2 below");
      flit(1, 1, lo, '1, "R2 low bound");
      flit(1, 1, lo + 40'h123, '1, "R2 inside");
      flit(1, 1, m_hi[i], '1, "R2 high bound");
      flit(1, 1, m_hi[i] + 1, '1, "R2 above");
    end

    // overlap: entry 5 widened over entry 3, lowest index wins
    cfg(5, 1, 40'h10_0000_3000, 40'h10_0000_5FFF, 40'h777, 2'd0);
    flit(1, 1, 40'h10_0000_3010, '1, "R3 overlap lowest");
    chk(out_valid == 4'b1000, "R3 link of entry 3", 64'(out_valid), 64'b1000);
    cfg(3, 0, 0, 0, 0, 0);
    flit(1, 1, 40'h10_0000_3010, '1, "R8 cleared, next entry");
    chk(out_valid == 4'b0001, "R3 link of entry 5", 64'(out_valid), 64'b0001);

    // same-cycle write and lookup: clear entry 1 while a flit targets it
    @(negedge clk);
    cfg_we = 1; cfg_set = 0; cfg_idx = 3'd1;
    in_valid = 1; in_sof = 1; in_eof = 1; in_addr = 40'h10_0000_1000; out_ready = '1;
    #1;
    chk(out_valid == 4'b0010 && err_miss == 0, "R8 old entry used", 64'(out_valid), 64'b0010);
    @(posedge clk); #1 cfg_we = 0; in_valid = 0;
    m_val[1] = 0; b_hit = 1; b_off = 40'h111; b_link = 2'd1;
    flit(1, 1, 40'h10_0000_1000, '1, "R8 cleared next cycle");

    // multi-flit transaction, table rewritten mid-way
    flit(1, 0, 40'h10_0000_2004, '1, "R6 start");
    cfg(2, 1, 40'h10_0000_2000, 40'h10_0000_27FF, 40'h9999, 2'd3);
    flit(0, 0, 40'h10_0000_2008, '1, "R6 continuation keeps route");
    chk(out_valid == 4'b0100 && out_addr == 40'h10_0000_2008 + 40'h222, "R6 old link/off",
        64'(out_addr), 64'(40'h10_0000_2008 + 40'h222));
    flit(0, 1, 40'h10_0000_200C, '1, "R6 last");
    flit(1, 1, 40'h10_0000_2004, '1, "R8 rewritten entry");

    // backpressure: only the selected link's ready matters
    flit(1, 1, 40'h10_0000_4000, 4'b1110, "R7 stall");
    flit(1, 1, 40'h10_0000_4000, 4'b0001, "R7 other links ignored");
    flit(1, 0, 40'h10_0000_6000, 4'b1011, "R7 stall start");
    flit(1, 0, 40'h10_0000_6000, 4'b0100, "R7 start accepted");
    flit(0, 1, 40'h10_0000_6010, 4'b1011, "R7 stall continuation");
    flit(0, 1, 40'h10_0000_6010, 4'b0100, "R7 continuation accepted");

    // missed transaction with continuation flits
    flit(1, 0, 40'hFF_0000_0000, '1, "R9 start miss");
    flit(0, 0, 40'h10_0000_6000, '1, "R9 silent drop");
    flit(0, 1, 40'h10_0000_6008, '1, "R9 silent drop");

    // saturation of the 4-bit counter
    for (int i = 0; i < 20; i++) flit(1, 1, 40'h1, '1, "R4 miss");
    @(negedge clk);
    chk(miss_cnt == 4'hF, "R4 saturate", 64'(miss_cnt), 64'hF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule